// File: doc/BRIEF.md
# CPU Debug Halt and Instruction Injection Port

This block is a register-mapped debug port placed next to a small 32-bit in-order CPU core. A bus master uses it to stop the core, hold it in reset, let it run, or advance it by a single instruction. While the core is stopped, the master can push one instruction word into the pipeline and read back the value that instruction writes back.

The port also holds a set of hardware breakpoint comparators that watch the fetch address. When an armed comparator matches, the fetched instruction is dropped and the core stops. The fetch address is kept in the result register so the master can learn where the core stopped. The pipeline itself lies outside the block. The port talks to it through a halt request, a reset request, an injection valid/data pair, a busy input, a writeback valid/data pair, the fetch address and a break-hit strobe.

The bus has a byte address, a write strobe, write data and read data. Reads are combinational. Offset 0x00 is the status/control word, 0x04 is the injection/result register, and 0x40 + 4*n is breakpoint n.

Top module: `dbg_halt_port`

## Requirements
- R1: Reading offset 0x00 returns the status word with these bits: bit0 reset held, bit1 halted, bit2 busy (core busy input OR an injected instruction not yet written back), bit3 stopped by breakpoint, bit4 step mode. All other bits read 0. The `coreHalt` and `coreReset` outputs follow the halted and reset bits. After reset all five bits are 0.
- R2: In a write to offset 0x00, bit16 sets reset and bit24 clears it. Bit17 sets halt and bit25 releases it. A bit written as 0 changes nothing. If the set and clear bits of one pair are both 1, the set wins.
- R3: Writing bit16 and bit17 together, and then bit24 alone, leaves the core halted and out of reset (status 0x02).
- R4: A halt release written with bit4 = 1 (and bit17 = 0) drops `coreHalt` for exactly one cycle and then raises it again, so the core runs one instruction. The step bit reads 1 until the next release that has bit4 = 0.
- R5: A write to offset 0x04 while the core is halted and not busy drives `injValid` high for one cycle, with the written word on `injInstr`. The busy status bit stays 1 until the core's next writeback.
- R6: A write to offset 0x04 while the core is running, or while the busy bit is 1, produces no `injValid` pulse.
- R7: Reading offset 0x04 returns the last `wbData` captured on `wbValid`; after reset it reads 0.
- R8: Breakpoint n sits at offset 0x40 + 4*n, for n below NUM_BP. Bit0 arms it and bits 31:2 hold the word address to compare. Bit1 reads 0. Writing 0 disarms it. A read returns the stored value.
- R9: When the core is running and not in reset, a valid fetch whose address bits 31:2 equal an armed comparator asserts `breakHit` in the same cycle. The core is halted from the next cycle on, the breakpoint status bit is set, and the result register holds the fetch address (this takes priority over a writeback in the same cycle).
- R10: The breakpoint status bit is cleared by the next halt release (with or without step).
- R11: Unmapped offsets, misaligned offsets and breakpoint slots at or above NUM_BP read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWrite | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for busAddr |
| coreHalt | output | 1 | Halt request to the core |
| coreReset | output | 1 | Reset request to the core |
| injValid | output | 1 | One-cycle strobe: injected instruction present |
| injInstr | output | 32 | Injected instruction word |
| coreBusy | input | 1 | Core pipeline busy |
| wbValid | input | 1 | Core writeback valid |
| wbData | input | 32 | Core writeback value |
| fetchValid | input | 1 | Core fetch address valid |
| fetchPc | input | 32 | Core fetch address |
| breakHit | output | 1 | Breakpoint match: drop this fetch |

## Verification
Control writes show up in the status word and in `coreHalt`/`coreReset` one clock edge after the write. The bench therefore reads status at the falling edge right after the write edge. A step releases the core for the cycle after the write and halts it again one edge later, so the step result and the model's program counter are checked two edges after the write. An injected word reaches `injValid` one edge after the write, and the core model writes it back two edges later. The result and the cleared busy bit are read after a further edge. A breakpoint halt is checked once enough edges have passed for the modelled core to step up to the armed address, and then again to show that nothing moves afterwards.

// File: rtl/dbg_port_pkg.sv
package dbg_port_pkg;

  localparam int WORD_W    = 32;
  localparam int BP_SLOT_W = 4;   // slots 0x40..0x7C

  // control bits extracted from a status-word write
  typedef struct packed {
    logic rstSet;
    logic rstClr;
    logic haltSet;
    logic haltRel;
    logic stepReq;
  } ctl_cmd_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic                 injLoad;
    logic                 bpWr;
    logic [BP_SLOT_W-1:0] bpIdx;
    logic                 rdStatus;
    logic                 rdResult;
    logic                 rdBp;
    logic                 runOk;
  } dp_strobe_t;

endpackage

// File: rtl/dbg_ctrl.sv
module dbg_ctrl
  import dbg_port_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_BP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  ctl_cmd_t          cmd,
  input  logic              coreBusy,
  input  logic              wbValid,
  input  logic              brkHit,
  output dp_strobe_t        strb,
  output logic              haltQ,
  output logic              resetQ,
  output logic              injValid,
  output logic [WORD_W-1:0] statusWord
);

  localparam int HI_W = ADDR_W - 6;

  logic isStatus, isInj, isBp;
  logic stepRunQ, stepModeQ, brkQ, injPendQ;
  logic stWr, relCmd, injAccept, haltD;

  always_comb begin
    isStatus = (busAddr == ADDR_W'(0));
    isInj    = (busAddr == ADDR_W'(4));
    isBp     = (busAddr[ADDR_W-1:6] == HI_W'(1)) && (busAddr[1:0] == 2'b00) &&
               (32'(busAddr[5:2]) < NUM_BP);
  end

  assign stWr      = busWrite && isStatus;
  assign relCmd    = stWr && cmd.haltRel && !cmd.haltSet;
  assign injAccept = busWrite && isInj && haltQ && !coreBusy && !injPendQ;

  always_comb begin
    haltD = haltQ;
    if (relCmd)                haltD = 1'b0;
    if (stepRunQ)              haltD = 1'b1;
    if (brkHit)                haltD = 1'b1;
    if (stWr && cmd.haltSet)   haltD = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      haltQ     <= 1'b0;
      resetQ    <= 1'b0;
      stepRunQ  <= 1'b0;
      stepModeQ <= 1'b0;
      brkQ      <= 1'b0;
      injPendQ  <= 1'b0;
      injValid  <= 1'b0;
    end else begin
      haltQ    <= haltD;
      stepRunQ <= relCmd && cmd.stepReq;
      if (stWr && cmd.rstSet)      resetQ <= 1'b1;
      else if (stWr && cmd.rstClr) resetQ <= 1'b0;
      if (relCmd) stepModeQ <= cmd.stepReq;
      if (brkHit)      brkQ <= 1'b1;
      else if (relCmd) brkQ <= 1'b0;
      injValid <= injAccept;
      if (injAccept)    injPendQ <= 1'b1;
      else if (wbValid) injPendQ <= 1'b0;
    end
  end

  always_comb begin
    strb          = '0;
    strb.injLoad  = injAccept;
    strb.bpWr     = busWrite && isBp;
    strb.bpIdx    = busAddr[5:2];
    strb.rdStatus = isStatus;
    strb.rdResult = isInj;
    strb.rdBp     = isBp;
    strb.runOk    = !haltQ && !resetQ;
  end

  assign statusWord = {27'd0, stepModeQ, brkQ, (coreBusy | injPendQ), haltQ, resetQ};

endmodule

// File: rtl/dbg_dpath.sv
module dbg_dpath
  import dbg_port_pkg::*;
#(
  parameter int NUM_BP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dp_strobe_t        strb,
  input  logic [WORD_W-1:0] busWdata,
  input  logic [WORD_W-1:0] statusWord,
  input  logic              wbValid,
  input  logic [WORD_W-1:0] wbData,
  input  logic              fetchValid,
  input  logic [WORD_W-1:0] fetchPc,
  output logic              brkHit,
  output logic [WORD_W-1:0] injInstr,
  output logic [WORD_W-1:0] busRdata
);

  localparam int CMP_W = WORD_W - 2;

  logic [CMP_W-1:0]  bpAddr [NUM_BP];
  logic [NUM_BP-1:0] bpEn;
  logic [NUM_BP-1:0] matchVec;
  logic [WORD_W-1:0] resQ;

  for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bpAddr[g] <= '0;
        bpEn[g]   <= 1'b0;
      end else if (strb.bpWr && strb.bpIdx == BP_SLOT_W'(g)) begin
        bpAddr[g] <= busWdata[WORD_W-1:2];
        bpEn[g]   <= busWdata[0];
      end
    end
    assign matchVec[g] = bpEn[g] && (bpAddr[g] == fetchPc[WORD_W-1:2]);
  end

  assign brkHit = fetchValid && strb.runOk && (|matchVec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resQ     <= '0;
      injInstr <= '0;
    end else begin
      if (brkHit)       resQ <= fetchPc;
      else if (wbValid) resQ <= wbData;
      if (strb.injLoad) injInstr <= busWdata;
    end
  end

  always_comb begin
    busRdata = '0;
    if (strb.rdStatus) busRdata = statusWord;
    if (strb.rdResult) busRdata = resQ;
    if (strb.rdBp) begin
      for (int i = 0; i < NUM_BP; i++)
        if (32'(strb.bpIdx) == i) busRdata = {bpAddr[i], 1'b0, bpEn[i]};
    end
  end

endmodule

// File: rtl/dbg_halt_port.sv
module dbg_halt_port
  import dbg_port_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_BP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              coreHalt,
  output logic              coreReset,
  output logic              injValid,
  output logic [31:0]       injInstr,
  input  logic              coreBusy,
  input  logic              wbValid,
  input  logic [31:0]       wbData,
  input  logic              fetchValid,
  input  logic [31:0]       fetchPc,
  output logic              breakHit
);

  ctl_cmd_t          cmd;
  dp_strobe_t        strb;
  logic [WORD_W-1:0] statusWord;

  always_comb begin
    cmd.rstSet  = busWdata[16];
    cmd.rstClr  = busWdata[24];
    cmd.haltSet = busWdata[17];
    cmd.haltRel = busWdata[25];
    cmd.stepReq = busWdata[4];
  end

  dbg_ctrl #(.ADDR_W(ADDR_W), .NUM_BP(NUM_BP)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrite(busWrite),
    .cmd(cmd), .coreBusy(coreBusy), .wbValid(wbValid), .brkHit(breakHit),
    .strb(strb), .haltQ(coreHalt), .resetQ(coreReset), .injValid(injValid),
    .statusWord(statusWord)
  );

  dbg_dpath #(.NUM_BP(NUM_BP)) i_dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .busWdata(busWdata),
    .statusWord(statusWord), .wbValid(wbValid), .wbData(wbData),
    .fetchValid(fetchValid), .fetchPc(fetchPc), .brkHit(breakHit),
    .injInstr(injInstr), .busRdata(busRdata)
  );

endmodule

// File: rtl/dbg_halt_port_chk.sv
module dbg_halt_port_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrite,
  input logic [31:0]       busWdata,
  input logic              coreHalt,
  input logic              coreReset,
  input logic              injValid,
  input logic              breakHit
);

  logic stWr, stepWr;
  assign stWr   = busWrite && (busAddr == ADDR_W'(0));
  assign stepWr = stWr && busWdata[25] && busWdata[4] && !busWdata[17];

  AST_HALT_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (stWr && busWdata[17]) |=> coreHalt);  // R2
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stWr && busWdata[24] && !busWdata[16]) |=> !coreReset);  // R2
  AST_STEP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (stepWr && !breakHit) |=> !coreHalt);  // R4
  AST_STEP_REHALT: assert property (@(posedge clk) disable iff (!rst_n)
    (!coreHalt && $past(stepWr) && !stWr) |=> coreHalt);  // R4
  AST_INJ_WHEN_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    injValid |-> $past(coreHalt));  // R5
  AST_INJ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    injValid |=> !injValid);  // R5
  AST_BREAK_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    breakHit |=> coreHalt);  // R9

endmodule

bind dbg_halt_port dbg_halt_port_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrite(busWrite),
  .busWdata(busWdata), .coreHalt(coreHalt), .coreReset(coreReset),
  .injValid(injValid), .breakHit(breakHit)
);

// File: tb/test_dbg_halt_port.sv
module test_dbg_halt_port;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  localparam logic [31:0] VEC_W [NVEC] = '{
    32'h0002_0000, 32'h0001_0000, 32'h0000_0000, 32'h0100_0000, 32'h0200_0000,
    32'h0003_0000, 32'h0100_0000, 32'h0202_0000, 32'h0101_0000, 32'h0100_0000};
  localparam logic [31:0] VEC_S [NVEC] = '{
    32'h02, 32'h03, 32'h03, 32'h02, 32'h00,
    32'h03, 32'h02, 32'h02, 32'h03, 32'h02};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrite = 1'b0;
  logic [31:0] busWdata = '0, busRdata;
  logic coreHalt, coreReset, injValid, breakHit;
  logic [31:0] injInstr;
  logic coreBusy = 1'b0, wbValid = 1'b0, fetchValid;
  logic [31:0] wbData = '0, pc = 32'h100, injHold = '0;
  logic injDly = 1'b0;
  int nChecks = 0, nFail = 0, injCount = 0;
  logic [31:0] rv, p;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_halt_port i_dbg_halt_port (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .coreHalt(coreHalt),
    .coreReset(coreReset), .injValid(injValid), .injInstr(injInstr),
    .coreBusy(coreBusy), .wbValid(wbValid), .wbData(wbData),
    .fetchValid(fetchValid), .fetchPc(pc), .breakHit(breakHit)
  );

  // core model: one instruction per unhalted cycle, injected ones take two cycles
  assign fetchValid = !coreHalt && !coreReset;
  always @(posedge clk) begin
    wbValid <= 1'b0;
    injDly  <= injValid;
    if (injValid) begin
      injHold  <= injInstr;
      injCount <= injCount + 1;
    end
    if (injDly) begin
      wbValid <= 1'b1;
      wbData  <= injHold ^ 32'hFFFF_0000;
    end else if (!coreHalt && !coreReset && !breakHit) begin
      pc      <= pc + 32'd4;
      wbValid <= 1'b1;
      wbData  <= pc ^ 32'h8000_0000;
    end
    if (coreReset) pc <= 32'h100;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    int c0;
    idle(3);
    // R1 R7 R8: reset state, checked while reset is held
    rd(8'h00, rv); chk("R1 reset status", rv, 32'h0);
    rd(8'h04, rv); chk("R7 reset result", rv, 32'h0);
    rd(8'h40, rv); chk("R8 reset bp0", rv, 32'h0);
    chk("R1 coreHalt/coreReset low", {30'd0, coreHalt, coreReset}, 32'h0);
    rst_n = 1'b1;
    idle(2);

    // R2 R3: table of control writes
    for (int i = 0; i < NVEC; i++) begin
      wr(8'h00, VEC_W[i]);
      rd(8'h00, rv);
      chk("R2/R3 status vector", rv, VEC_S[i]);
      chk("R1 pins follow status", {30'd0, coreHalt, coreReset}, VEC_S[i] & 32'h3);
    end

    // R5 R7: injection while halted
    c0 = injCount;
    wr(8'h04, 32'h1234_5678);
    rd(8'h00, rv); chk("R5 busy while injected", rv, 32'h06);
    chk("R5 injInstr", injInstr, 32'h1234_5678);
    idle(3);
    chk("R5 one pulse", 32'(injCount - c0), 32'd1);
    rd(8'h04, rv); chk("R7 injected result", rv, 32'hEDCB_5678);
    rd(8'h00, rv); chk("R5 busy cleared", rv, 32'h02);

    // R6: injection ignored while busy
    coreBusy = 1'b1;
    rd(8'h00, rv); chk("R1 busy input", rv, 32'h06);
    c0 = injCount;
    wr(8'h04, 32'hDEAD_0001);
    idle(4);
    chk("R6 no inject when busy", 32'(injCount - c0), 32'd0);
    coreBusy = 1'b0;

    // R6: injection ignored while running
    wr(8'h00, 32'h0200_0000);
    c0 = injCount;
    wr(8'h04, 32'hDEAD_0002);
    idle(4);
    chk("R6 no inject when running", 32'(injCount - c0), 32'd0);
    wr(8'h00, 32'h0002_0000);

    // R4: single step
    p = pc;
    wr(8'h00, 32'h0200_0010);
    idle(2);
    rd(8'h00, rv); chk("R4 step status", rv, 32'h12);
    chk("R4 one instruction", pc, p + 32'd4);
    rd(8'h04, rv); chk("R7 step result", rv, p ^ 32'h8000_0000);
    idle(3);
    chk("R4 stays halted", pc, p + 32'd4);

    // R8 R9: breakpoint while running
    p = pc;
    wr(8'h40, (p + 32'd12) | 32'h1);
    rd(8'h40, rv); chk("R8 bp0 readback", rv, (p + 32'd12) | 32'h1);
    wr(8'h00, 32'h0200_0000);
    idle(10);
    rd(8'h00, rv); chk("R9 break status", rv, 32'h0A);
    rd(8'h04, rv); chk("R9 result holds pc", rv, p + 32'd12);
    chk("R9 instruction not executed", pc, p + 32'd12);

    // R8 R10: disarm, resume clears flag
    wr(8'h40, 32'h0);
    rd(8'h40, rv); chk("R8 bp0 disarmed", rv, 32'h0);
    wr(8'h00, 32'h0200_0000);
    rd(8'h00, rv); chk("R10 flag cleared on resume", rv, 32'h00);
    idle(3);
    wr(8'h00, 32'h0002_0000);

    // R9 R10: step into an armed breakpoint (bp1)
    p = pc;
    wr(8'h44, p | 32'h1);
    wr(8'h00, 32'h0200_0010);
    idle(2);
    rd(8'h00, rv); chk("R9 step into break", rv, 32'h1A);
    chk("R9 step break not executed", pc, p);
    wr(8'h44, 32'h0);
    wr(8'h00, 32'h0200_0010);
    idle(2);
    rd(8'h00, rv); chk("R10 step clears flag", rv, 32'h12);

    // R11: unmapped offsets
    wr(8'h0C, 32'h0200_0000);
    rd(8'h00, rv); chk("R11 write to 0x0C no effect", rv, 32'h12);
    wr(8'h48, 32'hFFFF_FFFF);
    rd(8'h48, rv); chk("R11 slot beyond NUM_BP", rv, 32'h0);
    rd(8'h08, rv); chk("R11 read 0x08", rv, 32'h0);
    rd(8'h42, rv); chk("R11 misaligned", rv, 32'h0);
    p = pc;
    wr(8'h00, 32'h0200_0000);
    idle(6);
    chk("R11 no stray breakpoint", pc, p + 32'd24);

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule